// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block converts a two-channel serial audio stream into parallel words. The stream has three lines: a bit clock, a frame clock that marks which channel is on the wire, and a data line. The block runs on a faster system clock. It passes all three lines through two-flop synchronizers, finds the rising edges of the bit clock, and shifts in the data bit at each of those edges.

A 3-bit format code sets where the data word sits inside each half-frame:

- In the leading-aligned layouts, the word starts at the first bit after the frame clock changes.
- In the I2S layout, the word starts one bit later.
- In the trailing-aligned layouts, the word ends on the last bit before the frame clock changes.

Words shorter than 24 bits are sign-extended. After the right channel of a frame has completed, the block emits a one-cycle strobe together with both channel words of that frame.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted, and after it is released until the first strobe, `sample_valid` is low and both output words are zero.
- R2: With format 010, data is MSB first, two's complement, and sampled on rising bit-clock edges. The output word is the first 24 bits after each frame-clock change, and all later bits of the half-frame are ignored. Frame clock high marks the left channel. A half-frame of 24 bit clocks (48fs) is enough.
- R3: With format 011 (I2S), frame clock low marks the left channel. The first bit after each frame-clock change is ignored, and the next 24 bits form the word, MSB first.
- R4: With format 100, the word is the last 24 bits of each half-frame, and earlier bits are ignored. Frame clock high marks the left channel.
- R5: With format 001, the word is the last 20 bits of each half-frame, sign-extended from bit 19 to 24 bits. Earlier bits are ignored.
- R6: With format 000, the word is the last 16 bits of each half-frame, sign-extended from bit 15 to 24 bits. This works with 16 bit clocks per half-frame (32fs) as well as with 32.
- R7: `sample_valid` is a single system-clock pulse. It is raised after the rising bit-clock edge at which the frame clock leaves the right channel. It carries the left and right words of the frame that has just ended. Between pulses both output words hold their values.
- R8: After reset, the first, partial half-frame is discarded. There is exactly one strobe per complete left-then-right pair that follows it, and no strobe for a trailing left half whose right half never arrives.
- R9: With format 010, a 16-bit word sent MSB first with its eight low bits at zero is delivered as that value with zeros in bits 7..0.
- R10: Format codes 101, 110 and 111 are received like format 010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversampling the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | Serial bit clock, asynchronous to `clk` |
| lrck_in | input | 1 | Frame clock selecting the channel |
| sdata_in | input | 1 | Serial data, changing on falling bit-clock edges |
| fmt | input | 3 | Frame layout select (see R2 to R10) |
| left_word | output | 24 | Left channel word of the last completed frame |
| right_word | output | 24 | Right channel word of the last completed frame |
| sample_valid | output | 1 | One-cycle strobe when a new frame pair is presented |

## Verification
The hardest situation to reach is the one where the trailing-aligned formats read only the tail of a half-frame, while the leading-aligned formats must ignore that same tail. To get there, the stimulus fills every bit outside the data window with random bits. It also runs each format at more than one half-frame length: 16, 20 and 24 bit clocks at the minimum and 32 as the usual case. This means a wrong window position or a wrong word length shows up as corrupted words.

The discard of the partial first half-frame is forced by a short preamble on the right-channel level before each run. A trailing left half is then sent with no right half after it, to confirm that no strobe appears for it.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int W  = 24,
  parameter int CW = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk_in,
  input  logic         lrck_in,
  input  logic         sdata_in,
  input  logic [2:0]   fmt,
  output logic [W-1:0] left_word,
  output logic [W-1:0] right_word,
  output logic         sample_valid
);

  localparam logic [CW-1:0] IDX_MAX = '1;
  localparam logic [CW-1:0] WIN_LEN = CW'(W);

  logic [2:0]    bck_q;
  logic [1:0]    lr_q, sd_q;
  logic          lr_prev, primed, started, have_left;
  logic [CW-1:0] idx;
  logic [W-1:0]  sh, left_hold, word;

  wire rise     = bck_q[1] & ~bck_q[2];
  wire lr_now   = lr_q[1];
  wire is_i2s   = (fmt == 3'b011);
  wire is_lsb   = (fmt == 3'b000) || (fmt == 3'b001) || (fmt == 3'b100);
  wire change   = primed && (lr_now != lr_prev);
  wire left_end = lr_prev ^ is_i2s;

  wire [CW-1:0] cur_idx = change ? '0 : idx;
  wire in_win = is_lsb ? 1'b1
              : is_i2s ? (cur_idx != '0 && cur_idx <= WIN_LEN)
              :          (cur_idx < WIN_LEN);

  always_comb begin
    case (fmt)
      3'b000:  word = {{(W-16){sh[15]}}, sh[15:0]};
      3'b001:  word = {{(W-20){sh[19]}}, sh[19:0]};
      default: word = sh;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bck_q <= '0;
      lr_q  <= '0;
      sd_q  <= '0;
    end else begin
      bck_q <= {bck_q[1:0], bclk_in};
      lr_q  <= {lr_q[0], lrck_in};
      sd_q  <= {sd_q[0], sdata_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_prev      <= 1'b0;
      primed       <= 1'b0;
      started      <= 1'b0;
      have_left    <= 1'b0;
      idx          <= '0;
      sh           <= '0;
      left_hold    <= '0;
      left_word    <= '0;
      right_word   <= '0;
      sample_valid <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      if (rise) begin
        primed  <= 1'b1;
        lr_prev <= lr_now;
        idx     <= (cur_idx == IDX_MAX) ? cur_idx : cur_idx + 1'b1;
        if (in_win) sh <= {sh[W-2:0], sd_q[1]};
        if (change) begin
          started <= 1'b1;
          if (started) begin
            if (left_end) begin
              left_hold <= word;
              have_left <= 1'b1;
            end else if (have_left) begin
              left_word    <= left_hold;
              right_word   <= word;
              sample_valid <= 1'b1;
              have_left    <= 1'b0;
            end
          end
        end
      end
    end
  end

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  assert_after_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $past(rise));

  assert_hold_words_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> ($stable(left_word) && $stable(right_word)));

  assert_sext16_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && $past(fmt) == 3'b000) |->
      (right_word[W-1:15] == '0 || right_word[W-1:15] == '1));

  assert_sext20_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && $past(fmt) == 3'b001) |->
      (right_word[W-1:19] == '0 || right_word[W-1:19] == '1));

endmodule

// File: tb/serial_audio_rx_test.sv
module serial_audio_rx_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk_in = 1'b0, lrck_in = 1'b0, sdata_in = 1'b0;
  logic [2:0] fmt = 3'b010;
  logic [23:0] left_word, right_word;
  logic sample_valid;

  int checks = 0, errors = 0, vcount = 0, nexp = 0, cycles = 0;
  logic [23:0] exp_l [0:15];
  logic [23:0] exp_r [0:15];
  string tag = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_audio_rx uut (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .lrck_in(lrck_in),
    .sdata_in(sdata_in), .fmt(fmt), .left_word(left_word),
    .right_word(right_word), .sample_valid(sample_valid)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic [23:0] act, input logic [23:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
      summary();
    end
  end

  always @(negedge clk) begin
    if (rst_n && sample_valid) begin
      if (vcount < nexp) begin
        check(tag, "left word", left_word, exp_l[vcount]);
        check(tag, "right word", right_word, exp_r[vcount]);
      end else begin
        check("R8", "extra strobe index", 24'(vcount), 24'(nexp));
      end
      vcount++;
    end
  end

  function automatic logic bitv(input logic [2:0] f, input int h, input int p,
                                input logic [23:0] w, input logic junk);
    case (f)
      3'b011: if (p >= 1 && p <= 24) return w[24-p];
      3'b100: if (p >= h-24) return w[h-1-p];
      3'b001: if (p >= h-20) return w[h-1-p];
      3'b000: if (p >= h-16) return w[h-1-p];
      default: if (p < 24) return w[23-p];
    endcase
    return junk;
  endfunction

  function automatic logic [23:0] expect_word(input logic [2:0] f, input logic [23:0] w);
    case (f)
      3'b000:  return {{8{w[15]}}, w[15:0]};
      3'b001:  return {{4{w[19]}}, w[19:0]};
      default: return w;
    endcase
  endfunction

  task automatic send_half(input logic lv, input int h, input logic [2:0] f, input logic [23:0] w);
    for (int p = 0; p < h; p++) begin
      bclk_in  = 1'b0;
      lrck_in  = lv;
      sdata_in = bitv(f, h, p, w, 1'($urandom));
      tick(4);
      bclk_in = 1'b1;
      tick(4);
    end
  endtask

  task automatic run_seg(input logic [2:0] f, input int h, input int n,
                         input bit pad16, input string rtag);
    logic lv;
    logic [23:0] wl, wr;
    rst_n = 1'b0;
    bclk_in = 1'b0;
    tick(4);
    check("R1", "valid in reset", 24'(sample_valid), 24'd0);
    check("R1", "left in reset", left_word, 24'd0);
    fmt = f;
    tag = rtag;
    vcount = 0;
    nexp = 0;
    rst_n = 1'b1;
    tick(3);
    lv = (f == 3'b011) ? 1'b0 : 1'b1;
    send_half(~lv, 5, f, 24'h0);
    check("R8", "strobes after preamble", 24'(vcount), 24'd0);
    for (int k = 0; k < n; k++) begin
      wl = $urandom;
      wr = $urandom;
      if (k == 0) begin wl = 24'h800000; wr = 24'h7FFFFF; end
      if (k == 1) begin wl = 24'hFF8000; wr = 24'h007FFF; end
      if (k == 2) begin wl = 24'h0FFFFF; wr = 24'h080000; end
      if (pad16) begin wl[7:0] = 8'h0; wr[7:0] = 8'h0; end
      exp_l[k] = expect_word(f, wl);
      exp_r[k] = expect_word(f, wr);
      nexp = k + 1;
      send_half(lv, h, f, wl);
      send_half(~lv, h, f, wr);
    end
    send_half(lv, 6, f, 24'h0);
    bclk_in = 1'b0;
    send_half(~lv, 3, f, 24'h0);
    tick(20);
    check("R8", "strobe count", 24'(vcount), 24'(n));
    check("R7", "left held after last strobe", left_word, exp_l[n-1]);
    check("R7", "right held after last strobe", right_word, exp_r[n-1]);
  endtask

  initial begin
    void'($urandom(32'd2024));
    run_seg(3'b010, 32, 6, 1'b0, "R2");
    run_seg(3'b010, 24, 5, 1'b0, "R2");
    run_seg(3'b010, 32, 4, 1'b1, "R9");
    run_seg(3'b011, 32, 6, 1'b0, "R3");
    run_seg(3'b011, 25, 4, 1'b0, "R3");
    run_seg(3'b100, 32, 5, 1'b0, "R4");
    run_seg(3'b100, 24, 4, 1'b0, "R4");
    run_seg(3'b001, 32, 5, 1'b0, "R5");
    run_seg(3'b001, 20, 4, 1'b0, "R5");
    run_seg(3'b000, 16, 6, 1'b0, "R6");
    run_seg(3'b000, 32, 4, 1'b0, "R6");
    run_seg(3'b110, 32, 4, 1'b0, "R10");
    run_seg(3'b111, 28, 3, 1'b0, "R10");
    summary();
  end
endmodule